// File: doc/BRIEF.md
# Dual-Channel Disk Interrupt Gate

This block is the card-side register logic of a two-channel disk interface expansion card, as a host sees it over a byte-wide memory-mapped bus. Each channel has its own interrupt enable. The host changes an enable only by touching the channel's mask address. Any write to that address arms the channel and any read of it disarms the channel. Arming one channel always disarms the other, so the card forwards at most one drive's interrupt at a time.

Each channel also has a status location, which reports the raw drive interrupt line in bit 0 whether or not the channel is armed. The single card interrupt request is the OR of the armed channels' drive lines, registered once so that it cannot glitch. The block also holds a control byte at the bottom of the space, whose bits open the extended address window and steer the DMA signals to one channel. A fixed 4-bit card-type code can be read back one bit per byte. The taskfile data path and the drive protocol are outside the block.

The bus carries single-cycle register accesses with plain strobes, and there is no back-pressure. Every access completes in the cycle its strobe is high. Read data is driven combinationally during that cycle, and a read's side effect takes place at the closing clock edge. If both strobes are high in the same cycle, the write is performed and the read's side effect is dropped. `drv_irq` is assumed to be synchronous to `clk`.

Top module: `dual_irq_gate`

## Requirements
- R1: After reset both channel enables are clear, `card_irq` is 0, and the control byte is 0x00, so `ext_region_en` and `dma_chan_sel` are 0.
- R2: A write of any value, including 0x00, to a channel's mask address (channel 1 at 0x2200, channel 2 at 0x3200) sets that channel's enable at the clock edge. A read of the same address returns the enable in bit 0, with bits 7:1 at 0, and clears the enable at that edge.
- R3: Arming one channel clears the other channel's enable at the same edge, so at most one enable is ever set.
- R4: A read of a status address (channel 1 at 0x2290, channel 2 at 0x3290) returns that channel's raw `drv_irq` bit in bit 0 whatever its enable, with bits 7:1 at 0. Such a read has no side effect.
- R5: `card_irq` equals the OR over channels of (`drv_irq[i]` AND enable[i]), sampled at the previous clock edge. It therefore changes one cycle after an input or enable change.
- R6: The control byte at 0x0000 is read and written in full. Bit 5 drives `ext_region_en`. Bit 0 drives `dma_chan_sel`, where 0 selects channel 1 and 1 selects channel 2. Writing 0x00 clears both outputs.
- R7: Reading 0x2280 + 4*k returns bit k of the card-type code in bit 0 and 0 in bits 7:1, for k = 0..3. The default code is 3.
- R8: A read of any address not listed above returns 0x00. A write to such an address, or to a status or identity address, changes neither enable nor the control byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 14 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| drv_irq | input | 2 | Raw interrupt lines from drive channels 1 and 2 (bit 0 is channel 1) |
| card_irq | output | 1 | Registered, gated card interrupt request |
| ext_region_en | output | 1 | Extended address window enable (control bit 5) |
| dma_chan_sel | output | 1 | DMA routing select (control bit 0) |

## Verification
The assertions check on every cycle that no more than one enable is set, that a write to a mask address arms its channel and a lone read disarms it, that `card_irq` stays low one cycle after both channels are disarmed and rises one cycle after an armed channel's line is high, and that an undecoded read returns zero. The bench's scenarios cover the rest:
- the read value returned by a disarming read, and the exact cycle at which `card_irq` follows an enable change;
- the status bits following the raw lines while the channel is disarmed;
- the control byte's outputs and the identity code assembled from four reads;
- writes to undecoded, status and identity addresses leaving the enables and the control byte untouched, which the bench reads back through the bus.

// File: rtl/dual_irq_gate_pkg.sv
package dual_irq_gate_pkg;
  // Default address map of the card window (byte offsets)
  localparam int DEF_CTRL_ADDR = 'h0000;
  localparam int DEF_CH_BASE   = 'h2000;
  localparam int DEF_CH_STRIDE = 'h1000;
  localparam int DEF_MASK_OFS  = 'h0200;
  localparam int DEF_STAT_OFS  = 'h0290;
  localparam int DEF_ID_BASE   = 'h2280;
  localparam int DEF_ID_STEP   = 4;
  localparam int DEF_CARD_ID   = 3;
endpackage

// File: rtl/icg_addr_decode.sv
module icg_addr_decode #(
  parameter int ADDR_W    = 14,
  parameter int NUM_CH    = 2,
  parameter int ID_W      = 4,
  parameter int CTRL_ADDR = dual_irq_gate_pkg::DEF_CTRL_ADDR,
  parameter int CH_BASE   = dual_irq_gate_pkg::DEF_CH_BASE,
  parameter int CH_STRIDE = dual_irq_gate_pkg::DEF_CH_STRIDE,
  parameter int MASK_OFS  = dual_irq_gate_pkg::DEF_MASK_OFS,
  parameter int STAT_OFS  = dual_irq_gate_pkg::DEF_STAT_OFS,
  parameter int ID_BASE   = dual_irq_gate_pkg::DEF_ID_BASE,
  parameter int ID_STEP   = dual_irq_gate_pkg::DEF_ID_STEP
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ctrl_hit,
  output logic [NUM_CH-1:0] mask_hit,
  output logic [NUM_CH-1:0] stat_hit,
  output logic [ID_W-1:0]   id_hit,
  output logic              any_hit
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  assign ctrl_hit = (addr == CTRL_A);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(CH_BASE + c * CH_STRIDE + MASK_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(CH_BASE + c * CH_STRIDE + STAT_OFS);
    assign mask_hit[c] = (addr == MASK_A);
    assign stat_hit[c] = (addr == STAT_A);
  end

  for (genvar k = 0; k < ID_W; k++) begin : g_id
    localparam logic [ADDR_W-1:0] ID_A = ADDR_W'(ID_BASE + k * ID_STEP);
    assign id_hit[k] = (addr == ID_A);
  end

  assign any_hit = ctrl_hit | (|mask_hit) | (|stat_hit) | (|id_hit);
endmodule

// File: rtl/icg_irq_gate.sv
module icg_irq_gate #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] arm,
  input  logic [NUM_CH-1:0] disarm,
  input  logic [NUM_CH-1:0] drv_irq,
  output logic [NUM_CH-1:0] en_q,
  output logic              card_irq_q
);
  logic [NUM_CH-1:0] en_d;
  logic              any_arm;

  assign any_arm = |arm;

  // Arming is exclusive: the armed channel wins, every other channel drops
  for (genvar c = 0; c < NUM_CH; c++) begin : g_en
    always_comb begin
      if (any_arm)        en_d[c] = arm[c];
      else if (disarm[c]) en_d[c] = 1'b0;
      else                en_d[c] = en_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= '0;
      card_irq_q <= 1'b0;
    end else begin
      en_q       <= en_d;
      card_irq_q <= |(drv_irq & en_q);
    end
  end
endmodule

// File: rtl/icg_ctrl_reg.sv
module icg_ctrl_reg #(
  parameter int DATA_W     = 8,
  parameter int REGION_BIT = 5,
  parameter int ROUTE_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  output logic              region_en,
  output logic              route_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

  assign region_en = q[REGION_BIT];
  assign route_sel = q[ROUTE_BIT];
endmodule

// File: rtl/icg_read_mux.sv
module icg_read_mux #(
  parameter int DATA_W  = 8,
  parameter int NUM_CH  = 2,
  parameter int ID_W    = 4,
  parameter int CARD_ID = dual_irq_gate_pkg::DEF_CARD_ID
) (
  input  logic              rd,
  input  logic              ctrl_hit,
  input  logic [NUM_CH-1:0] mask_hit,
  input  logic [NUM_CH-1:0] stat_hit,
  input  logic [ID_W-1:0]   id_hit,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [NUM_CH-1:0] en_q,
  input  logic [NUM_CH-1:0] drv_irq,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ID_W-1:0] ID_BITS = ID_W'(CARD_ID);

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (ctrl_hit) rdata = ctrl_q;
      for (int c = 0; c < NUM_CH; c++) begin
        if (mask_hit[c]) rdata = DATA_W'(en_q[c]);
        if (stat_hit[c]) rdata = DATA_W'(drv_irq[c]);
      end
      for (int k = 0; k < ID_W; k++) begin
        if (id_hit[k]) rdata = DATA_W'(ID_BITS[k]);
      end
    end
  end
endmodule

// File: rtl/dual_irq_gate.sv
module dual_irq_gate #(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 8,
  parameter int NUM_CH  = 2,
  parameter int ID_W    = 4,
  parameter int CARD_ID = dual_irq_gate_pkg::DEF_CARD_ID
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] drv_irq,
  output logic              card_irq,
  output logic              ext_region_en,
  output logic              dma_chan_sel
);
  logic              ctrl_hit;
  logic [NUM_CH-1:0] mask_hit;
  logic [NUM_CH-1:0] stat_hit;
  logic [ID_W-1:0]   id_hit;
  logic              any_hit;
  logic [NUM_CH-1:0] arm;
  logic [NUM_CH-1:0] disarm;
  logic [NUM_CH-1:0] en_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              rd_only;

  icg_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .ID_W(ID_W)
  ) dec_i (
    .addr(bus_addr), .ctrl_hit(ctrl_hit), .mask_hit(mask_hit),
    .stat_hit(stat_hit), .id_hit(id_hit), .any_hit(any_hit)
  );

  // A write wins over a read issued in the same cycle
  assign rd_only = bus_rd & ~bus_wr;
  assign arm     = mask_hit & {NUM_CH{bus_wr}};
  assign disarm  = mask_hit & {NUM_CH{rd_only}};

  icg_irq_gate #(.NUM_CH(NUM_CH)) gate_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm),
    .drv_irq(drv_irq), .en_q(en_q), .card_irq_q(card_irq)
  );

  icg_ctrl_reg #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .we(bus_wr & ctrl_hit), .wdata(bus_wdata),
    .q(ctrl_q), .region_en(ext_region_en), .route_sel(dma_chan_sel)
  );

  icg_read_mux #(
    .DATA_W(DATA_W), .NUM_CH(NUM_CH), .ID_W(ID_W), .CARD_ID(CARD_ID)
  ) mux_i (
    .rd(bus_rd), .ctrl_hit(ctrl_hit), .mask_hit(mask_hit), .stat_hit(stat_hit),
    .id_hit(id_hit), .ctrl_q(ctrl_q), .en_q(en_q), .drv_irq(drv_irq),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/dual_irq_gate_chk.sv
module dual_irq_gate_chk #(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] mask_hit,
  input logic              any_hit,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] drv_irq,
  input logic              card_irq
);
  // R1: enables and request are clear on leaving reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0) && !card_irq);

  // R3: never more than one channel armed
  a_r3_one_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(en_q) <= 1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R2: write to mask address arms the channel
    a_r2_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && mask_hit[c]) |=> en_q[c]);
    // R2: lone read of mask address disarms the channel
    a_r2_read_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && mask_hit[c]) |=> !en_q[c]);
  end

  // R5: no request one cycle after both channels are disarmed
  a_r5_quiet_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !card_irq);

  // R5: an armed, active line raises the request one cycle later
  a_r5_armed_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (|(drv_irq & en_q)) |=> card_irq);

  // R8: undecoded reads return zero
  a_r8_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !any_hit) |-> (bus_rdata == '0));
endmodule

bind dual_irq_gate dual_irq_gate_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .mask_hit(mask_hit), .any_hit(any_hit),
  .en_q(en_q), .drv_irq(drv_irq), .card_irq(card_irq)
);

// File: tb/dual_irq_gate_tb_top.sv
module dual_irq_gate_tb_top;
  localparam logic [13:0] A_CTRL  = 14'h0000;
  localparam logic [13:0] A_MASK1 = 14'h2200;
  localparam logic [13:0] A_MASK2 = 14'h3200;
  localparam logic [13:0] A_STAT1 = 14'h2290;
  localparam logic [13:0] A_STAT2 = 14'h3290;
  localparam logic [13:0] A_ID0   = 14'h2280;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [1:0]  drv_irq = '0;
  logic        card_irq, ext_region_en, dma_chan_sel;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_irq_gate dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drv_irq(drv_irq), .card_irq(card_irq), .ext_region_en(ext_region_en),
    .dma_chan_sel(dma_chan_sel)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1", "card_irq after reset", card_irq, 0);
    chk("R1", "ext_region_en after reset", ext_region_en, 0);
    chk("R1", "dma_chan_sel after reset", dma_chan_sel, 0);
    rd(A_CTRL, v);  chk("R1", "control byte after reset", v, 8'h00);
    rd(A_MASK1, v); chk("R1", "ch1 enable after reset", v, 8'h00);
    rd(A_MASK2, v); chk("R1", "ch2 enable after reset", v, 8'h00);
  endtask

  task automatic t_arm();
    logic [7:0] v;
    wr(A_MASK1, 8'h00);
    rd(A_MASK1, v); chk("R2", "ch1 armed by zero write", v, 8'h01);
    rd(A_MASK1, v); chk("R2", "ch1 cleared by read", v, 8'h00);
    wr(A_MASK2, 8'hA5);
    rd(A_MASK2, v); chk("R2", "ch2 armed by write", v, 8'h01);
    rd(A_MASK2, v); chk("R2", "ch2 cleared by read", v, 8'h00);
  endtask

  task automatic t_exclusive();
    logic [7:0] v;
    wr(A_MASK1, 8'hFF); wr(A_MASK2, 8'hFF);
    rd(A_MASK1, v); chk("R3", "ch1 dropped when ch2 armed", v, 8'h00);
    rd(A_MASK2, v); chk("R3", "ch2 kept", v, 8'h01);
    wr(A_MASK2, 8'h11); wr(A_MASK1, 8'h22);
    rd(A_MASK2, v); chk("R3", "ch2 dropped when ch1 armed", v, 8'h00);
    rd(A_MASK1, v); chk("R3", "ch1 kept", v, 8'h01);
  endtask

  task automatic t_status();
    logic [7:0] v;
    drv_irq = 2'b01;
    rd(A_STAT1, v); chk("R4", "stat1 with line 01", v, 8'h01);
    rd(A_STAT2, v); chk("R4", "stat2 with line 01", v, 8'h00);
    drv_irq = 2'b10;
    rd(A_STAT1, v); chk("R4", "stat1 with line 10", v, 8'h00);
    rd(A_STAT2, v); chk("R4", "stat2 with line 10", v, 8'h01);
    drv_irq = 2'b11;
    rd(A_STAT1, v); chk("R4", "stat1 with line 11", v, 8'h01);
    rd(A_STAT2, v); chk("R4", "stat2 with line 11", v, 8'h01);
    drv_irq = 2'b00;
  endtask

  task automatic t_gate();
    logic [7:0] v;
    drv_irq = 2'b11;
    @(negedge clk); @(negedge clk);
    chk("R5", "no request while disarmed", card_irq, 0);
    wr(A_MASK2, 8'h00);
    chk("R5", "request not yet up at arming edge", card_irq, 0);
    @(negedge clk);
    chk("R5", "request one cycle after arming", card_irq, 1);
    drv_irq = 2'b01;
    @(negedge clk);
    chk("R5", "unarmed channel does not request", card_irq, 0);
    drv_irq = 2'b10;
    @(negedge clk);
    chk("R5", "armed channel requests", card_irq, 1);
    rd(A_MASK2, v);
    chk("R5", "request held through disarm edge", card_irq, 1);
    @(negedge clk);
    chk("R5", "request drops after disarm", card_irq, 0);
    drv_irq = 2'b00;
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(A_CTRL, 8'h21);
    chk("R6", "region enable from bit 5", ext_region_en, 1);
    chk("R6", "dma select from bit 0", dma_chan_sel, 1);
    rd(A_CTRL, v); chk("R6", "control readback", v, 8'h21);
    wr(A_CTRL, 8'h00);
    chk("R6", "region enable cleared by zero", ext_region_en, 0);
    chk("R6", "dma select cleared by zero", dma_chan_sel, 0);
  endtask

  task automatic t_ident();
    logic [7:0] v;
    logic [3:0] code;
    for (int k = 0; k < 4; k++) begin
      rd(A_ID0 + 14'(4 * k), v);
      code[k] = v[0];
      chk("R7", "identity upper bits", {24'h0, v[7:1], 1'b0}, 0);
    end
    chk("R7", "card type code", code, 4'd3);
  endtask

  task automatic t_undecoded();
    logic [7:0] v;
    wr(A_CTRL, 8'h20);
    wr(A_MASK1, 8'h00);
    wr(14'h2201, 8'hFF);
    wr(14'h0001, 8'hFF);
    wr(A_STAT1, 8'hFF);
    wr(A_ID0, 8'hFF);
    wr(14'h3201, 8'hFF);
    rd(A_CTRL, v);  chk("R8", "control untouched by stray writes", v, 8'h20);
    chk("R8", "region enable untouched", ext_region_en, 1);
    chk("R8", "dma select untouched", dma_chan_sel, 0);
    drv_irq = 2'b11;
    rd(14'h2000, v); chk("R8", "read 0x2000", v, 8'h00);
    rd(14'h2204, v); chk("R8", "read 0x2204", v, 8'h00);
    rd(14'h2291, v); chk("R8", "read 0x2291", v, 8'h00);
    rd(14'h3FFF, v); chk("R8", "read 0x3FFF", v, 8'h00);
    rd(A_MASK2, v); chk("R8", "ch2 not armed by stray write", v, 8'h00);
    rd(A_MASK1, v); chk("R8", "ch1 still armed", v, 8'h01);
    drv_irq = 2'b00;
    wr(A_CTRL, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arm();
    t_exclusive();
    t_status();
    t_gate();
    t_ctrl();
    t_ident();
    t_undecoded();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule